// File: doc/BRIEF.md
# Framed Serial Input for a 16-bit DAC

This block is the digital receive side of a 16-bit voltage-output converter. A host sends 24-bit frames over three wires: an active-low frame select, a serial clock and a data line. All three are asynchronous to the block's system clock. Each one is brought into the system clock domain through a two-stage synchronizer. Clock edges are then found by comparing each sampled value with the one before it.

While the frame select is low, the block takes one data bit, most significant bit first, on each falling edge of the serial clock. On the 24th falling edge it copies the code and the power mode from the frame into its output registers and raises a load strobe for one system clock. If the frame select returns high before the 24th edge, the partial frame is dropped. The frame select must also stay high for a set number of system clocks before the next frame is accepted.

After reset, the output code is zero and remains zero until a complete, valid frame arrives. A nonzero mode field puts the converter into one of three power-down states. In these states the code output is held at zero. The next frame whose mode field is zero leaves power-down and applies its own code in the same update.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is 24 bits, sent most significant bit first and sampled on falling edges of `sclk_i` while `fsync_ni` is low. Frame bits 15:0 are the code, bits 17:16 are the mode, and bits 23:18 are ignored.
- R2: On the 24th falling edge of a valid frame, `code_o` and `pd_mode_o` take their new values and `load_o` is high. These appear after the 4th rising `clk_i` edge that follows the serial clock edge reaching the pins. At all other times these outputs hold their values and `load_o` stays low.
- R3: After reset, `code_o` is 0, `pd_mode_o` is 0, `powered_down_o` is 0 and `load_o` is 0. They stay at these values until a valid frame completes.
- R4: If `fsync_ni` rises before the 24th falling edge, the frame is discarded. No output changes and `load_o` does not pulse.
- R5: Falling edges of `sclk_i` after the 24th, while `fsync_ni` is still low, have no effect on any output.
- R6: After a completed frame, an aborted frame or reset, `fsync_ni` must be seen high for at least `GAP_CYC` system clocks before a new frame is accepted. A frame that starts earlier is ignored as a whole.
- R7: A valid frame with a nonzero mode (01, 10 or 11) sets `pd_mode_o` to that value, sets `powered_down_o` to 1 and forces `code_o` to 0. The next valid frame with mode 00 clears power-down and shows its own code in the same update.
- R8: `load_o` is never high on two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| code_o | output | 16 | Converter code; 0 while powered down |
| load_o | output | 1 | One-cycle strobe on each accepted frame |
| pd_mode_o | output | 2 | Current mode field (00 = normal) |
| powered_down_o | output | 1 | High while the mode is nonzero |

## Verification
Each accepted frame is due exactly four system clocks after the bench drives the 24th falling serial clock edge. Two of those clocks are the synchronizer, one is the edge detection and shift, and one is the output register. The bench therefore schedules its expected update for that cycle number. It compares the code, mode, power-down flag and strobe on every falling system clock edge, so an update that arrives early or late fails, and so does a strobe outside its cycle. The stimulus holds every serial level for three system clocks, and it keeps frame-select gaps well away from the `GAP_CYC` threshold. This keeps the cycle of each expected result exact.

// File: rtl/dsf_pkg.sv
`timescale 1ns/1ps
package dsf_pkg;
    localparam int CODE_W  = 16;
    localparam int MODE_W  = 2;
    localparam int FRAME_W = 24;
    localparam int KEEP_W  = CODE_W + MODE_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        RX_GAP,
        RX_READY,
        RX_SHIFT,
        RX_DONE
    } rx_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CODE_W-1:0] code;
    } dac_word_t;
endpackage

// File: rtl/dsf_sync.sv
`timescale 1ns/1ps
module dsf_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsf_frame_rx.sv
`timescale 1ns/1ps
module dsf_frame_rx
    import dsf_pkg::*;
#(
    parameter int GAP_CYC = 8
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      fsync_ns_i,
    input  logic      sclk_s_i,
    input  logic      sdata_s_i,
    output logic      valid_o,
    output dac_word_t word_o
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   bits;
        logic [GAP_W-1:0]   gap;
        logic [KEEP_W-1:0]  shreg;
        logic               sclk_prev;
        logic               valid;
    } rx_regs_t;

    rx_regs_t rx_d, rx_q;
    logic     fall;

    always_comb begin
        rx_d           = rx_q;
        rx_d.valid     = 1'b0;
        rx_d.sclk_prev = sclk_s_i;
        fall           = rx_q.sclk_prev & ~sclk_s_i;
        unique case (rx_q.st)
            RX_GAP: begin
                if (fsync_ns_i) begin
                    if (rx_q.gap == GAP_W'(GAP_CYC - 1)) begin
                        rx_d.st = RX_READY;
                    end else begin
                        rx_d.gap = rx_q.gap + 1'b1;
                    end
                end else begin
                    rx_d.gap = '0;
                end
            end
            RX_READY: begin
                if (!fsync_ns_i) begin
                    rx_d.st   = RX_SHIFT;
                    rx_d.bits = '0;
                end
            end
            RX_SHIFT: begin
                if (fsync_ns_i) begin
                    rx_d.st  = RX_GAP;
                    rx_d.gap = '0;
                end else if (fall) begin
                    rx_d.shreg = {rx_q.shreg[KEEP_W-2:0], sdata_s_i};
                    if (rx_q.bits == CNT_W'(FRAME_W - 1)) begin
                        rx_d.st    = RX_DONE;
                        rx_d.valid = 1'b1;
                    end else begin
                        rx_d.bits = rx_q.bits + 1'b1;
                    end
                end
            end
            RX_DONE: begin
                if (fsync_ns_i) begin
                    rx_d.st  = RX_GAP;
                    rx_d.gap = '0;
                end
            end
            default: rx_d.st = RX_GAP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q           <= '0;
            rx_q.st        <= RX_GAP;
            rx_q.sclk_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign valid_o = rx_q.valid;
    assign word_o  = dac_word_t'(rx_q.shreg);

    // R4: a select rise mid-frame drops the frame with no strobe
    p_abort_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_q.st == RX_SHIFT && fsync_ns_i) |=> (rx_q.st == RX_GAP && !rx_q.valid));

    // R5: edges after the last bit leave the captured word alone
    p_extra_edges_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_q.st == RX_DONE && !fsync_ns_i) |=> ($stable(rx_q.shreg) && !rx_q.valid));

    // R6: select falling during the gap never opens a frame
    p_early_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_q.st == RX_GAP && !fsync_ns_i) |=> (rx_q.st == RX_GAP));

    // R1: a completed word is only produced from the shifting state
    p_valid_from_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_q.valid |-> ($past(rx_q.st) == RX_SHIFT && rx_q.st == RX_DONE));
endmodule

// File: rtl/dsf_out_reg.sv
`timescale 1ns/1ps
module dsf_out_reg
    import dsf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  dac_word_t         word_i,
    output logic [CODE_W-1:0] code_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              pd_o,
    output logic              load_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [MODE_W-1:0] mode;
        logic              load;
    } out_regs_t;

    out_regs_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.load = valid_i;
        if (valid_i) begin
            out_d.code = word_i.code;
            out_d.mode = word_i.mode;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pd_o   = |out_q.mode;
    assign code_o = pd_o ? '0 : out_q.code;
    assign mode_o = out_q.mode;
    assign load_o = out_q.load;
endmodule

// File: rtl/dac_serial_front.sv
`timescale 1ns/1ps
module dac_serial_front
    import dsf_pkg::*;
#(
    parameter int GAP_CYC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        fsync_ni,
    input  logic        sclk_i,
    input  logic        sdata_i,
    output logic [15:0] code_o,
    output logic        load_o,
    output logic [1:0]  pd_mode_o,
    output logic        powered_down_o
);
    logic [2:0] pins_s;
    logic       frame_valid;
    dac_word_t  frame_word;

    dsf_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({fsync_ni, sclk_i, sdata_i}),
        .sync_o (pins_s)
    );

    dsf_frame_rx #(
        .GAP_CYC(GAP_CYC)
    ) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fsync_ns_i(pins_s[2]),
        .sclk_s_i  (pins_s[1]),
        .sdata_s_i (pins_s[0]),
        .valid_o   (frame_valid),
        .word_o    (frame_word)
    );

    dsf_out_reg u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(frame_valid),
        .word_i (frame_word),
        .code_o (code_o),
        .mode_o (pd_mode_o),
        .pd_o   (powered_down_o),
        .load_o (load_o)
    );

    // R8: the strobe lasts exactly one clock
    p_load_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> !load_o);

    // R2: outputs move only together with the strobe
    p_hold_between_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_o |-> ($stable(code_o) && $stable(pd_mode_o)));

    // R7: no normal code is driven while powered down
    p_blank_in_pd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        powered_down_o |-> (code_o == '0));
endmodule

// File: tb/dac_serial_front_tb_top.sv
`timescale 1ns/1ps
module dac_serial_front_tb_top;
    localparam int GAP = 8;
    localparam int H   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdata = 1'b0;
    logic [15:0] code;
    logic        load;
    logic [1:0]  pd_mode;
    logic        pd;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    due = -1;
    bit    cmp_en = 1'b0;
    string cur_tag = "R3";

    logic [15:0] pend_code;
    logic [1:0]  pend_mode;
    logic [15:0] exp_store = '0;
    logic [1:0]  exp_mode = '0;
    logic        exp_load = 1'b0;
    logic [15:0] exp_code;

    always #2 clk = ~clk;

    dac_serial_front #(.GAP_CYC(GAP)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .fsync_ni      (fsync_n),
        .sclk_i        (sclk),
        .sdata_i       (sdata),
        .code_o        (code),
        .load_o        (load),
        .pd_mode_o     (pd_mode),
        .powered_down_o(pd)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // reference model, compared on every clock away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            if (cyc == due) begin
                exp_store = pend_code;
                exp_mode  = pend_mode;
                exp_load  = 1'b1;
            end else begin
                exp_load = 1'b0;
            end
            exp_code = (exp_mode != 2'b00) ? 16'h0 : exp_store;
            checks++;
            if (code !== exp_code || load !== exp_load || pd_mode !== exp_mode ||
                pd !== (exp_mode != 2'b00)) begin
                errors++;
                $display("FAIL %s cyc=%0d code=%h/%h load=%b/%b mode=%0d/%0d pd=%b/%b",
                         cur_tag, cyc, code, exp_code, load, exp_load, pd_mode, exp_mode,
                         pd, (exp_mode != 2'b00));
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // nbits falls while selected; ok marks a frame the model must accept
    task automatic send_frame(logic [23:0] w, int nbits, bit ok, int extra, int gap);
        fsync_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits + extra; i++) begin
            sdata = (i < 24) ? w[23-i] : 1'b1;
            wait_clk(H);
            sclk = 1'b0;
            if (i == 23 && ok) begin
                pend_code = w[15:0];
                pend_mode = w[17:16];
                due = cyc + 4;
            end
            wait_clk(H);
            sclk = 1'b1;
        end
        wait_clk(H);
        fsync_n = 1'b1;
        wait_clk(gap);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(1);
        cmp_en = 1'b1;
        check_val("R3 reset code", 32'(code), 32'h0);
        check_val("R3 reset mode", {30'b0, pd_mode}, 32'h0);
        check_val("R3 reset load", {31'b0, load}, 32'h0);
        wait_clk(20);

        cur_tag = "R4 abort before first write";
        send_frame(24'h00ABCD, 10, 1'b0, 0, 20);
        check_val("R3 R4 code still zero", 32'(code), 32'h0);

        cur_tag = "R1 R2 field decode";
        send_frame(24'hFC1234, 24, 1'b1, 0, 20);
        check_val("R1 code field", 32'(code), 32'h1234);

        cur_tag = "R5 extra edges";
        send_frame(24'h00A5C3, 24, 1'b1, 6, 20);
        check_val("R5 code after extra edges", 32'(code), 32'hA5C3);

        cur_tag = "R4 abort at 23 bits";
        send_frame(24'h00FFFF, 23, 1'b0, 0, 20);
        check_val("R4 code unchanged", 32'(code), 32'hA5C3);

        cur_tag = "R6 short gap";
        send_frame(24'h001111, 24, 1'b1, 0, 2);
        send_frame(24'h002222, 24, 1'b0, 0, 20);
        check_val("R6 early frame ignored", 32'(code), 32'h1111);
        send_frame(24'h003333, 24, 1'b1, 0, 20);
        check_val("R6 next frame accepted", 32'(code), 32'h3333);

        cur_tag = "R7 power down";
        send_frame(24'h02BEEF, 24, 1'b1, 0, 20);
        check_val("R7 pd flag", {31'b0, pd}, 32'h1);
        check_val("R7 code blanked", 32'(code), 32'h0);
        send_frame(24'h010000, 24, 1'b1, 0, 20);
        check_val("R7 mode 01", {30'b0, pd_mode}, 32'h1);
        send_frame(24'h030000, 24, 1'b1, 0, 20);
        check_val("R7 mode 11", {30'b0, pd_mode}, 32'h3);
        send_frame(24'h004321, 24, 1'b1, 0, 20);
        check_val("R7 exit applies code", 32'(code), 32'h4321);
        check_val("R7 exit clears pd", {31'b0, pd}, 32'h0);

        cur_tag = "R8 R2 back to back";
        send_frame(24'h000001, 24, 1'b1, 0, 12);
        send_frame(24'h00FFFF, 24, 1'b1, 0, 20);
        check_val("R2 final code", 32'(code), 32'hFFFF);

        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule